// File: doc/BRIEF.md
# Intermittent Wiper and Wash Sequencer

This block sequences a single wiper relay from a slow timing strobe. The strobe is nominally 320 Hz, so one tick is 3.125 ms. It takes three already-synchronised requests: an interval request, a wash request and a park-position level. Each request is filtered by counting ticks. From the filtered levels a small state machine produces relay-on pulses of fixed length, separated by a pause whose length is set by a count input. A wash request overrides interval wiping. The relay stays on while washing, and the block then finishes with a period of dry wiping.

A strap input selects how the block learns that the wiper is parked. When park feedback is used, the pause and the dry-wipe count both follow the debounced park level. Without it, both are pure tick counts. Every delay is a parameter given in ticks. The defaults are:

- interval filter: 32 ticks
- switch-on delay: 8 ticks
- relay pulse: 160 ticks
- wash pre-delay: 128 ticks
- wash release filter: 32 ticks
- park filter: 8 ticks
- dry time: 896 ticks
- dry laps: 3

A pause count of 872 gives the nominal pause of about 2.7 s. A wider count reaches about 11 s.

Top module: `wiper_seq`

## Requirements
- R1: A synchronous reset (`rst` high) holds `relay_on` low and clears all state. After reset is released, a held interval request needs the full filter and switch-on delay again.
- R2: An interval request (`int_req` high) held from a given clock makes `relay_on` rise on the tick that ends INT_DEB_TICKS plus ON_DLY_TICKS ticks of filtering and delay.
- R3: Every relay pulse caused by the interval request lasts exactly RELAY_TICKS ticks.
- R4: A request that passes the filter gives exactly one pulse if it drops before its filtered level would be seen at the end of that pulse.
- R5: A request shorter than INT_DEB_TICKS ticks never turns the relay on.
- R6: With `park_fb_en` low, the pause starts on the tick the pulse ends. While the request is held, the next pulse starts after `pause_ticks` ticks. A count of 0 acts as 1.
- R7: With `park_fb_en` high, the block does not start the pause at the end of a pulse while the filtered park level is low. The pause starts on the clock that sees `park_in` (1 = parked) held high for PARK_DEB_TICKS ticks.
- R8: A wash request (`wash_req` high) held for WASH_ON_TICKS ticks turns the relay on from any state, interval pulse or pause included. The relay stays on while the filtered wash level is high.
- R9: When the wash request is released, the relay stays on for WASH_OFF_TICKS ticks of release filtering. With `park_fb_en` low it then stays on for a further DRY_TICKS ticks.
- R10: With `park_fb_en` high, dry wiping ends on the clock that sees the DRY_CYCLES-th filtered rise of `park_in` after the release filter.
- R11: All counters advance only in clocks where `tick` is high. With `tick` low, no filter, delay or pulse makes progress.
- R12: Releasing the interval request during a pause returns the block to idle, and no further pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timing strobe, one clock wide |
| int_req | input | 1 | Interval request, active high |
| wash_req | input | 1 | Wash request, active high |
| park_in | input | 1 | Park level, 1 = wiper parked |
| park_fb_en | input | 1 | 1 = use park feedback for pause and dry laps |
| pause_ticks | input | PAUSE_W | Pause length in ticks |
| relay_on | output | 1 | Relay drive |

## Verification
Each result is due a fixed number of clocks after its stimulus, because every stage is a register. With `tick` high on every clock, the delays are as follows:

- An interval request raises `relay_on` N+D+1 clocks after it is applied, where N is the interval filter and D the switch-on delay.
- A wash request raises `relay_on` WASH_ON_TICKS+1 clocks after it is applied.
- A wash release drops `relay_on` WASH_OFF_TICKS+DRY_TICKS+1 clocks later.
- A parked level returning during a park wait gives the next pulse PARK_DEB_TICKS+pause+1 clocks later.

A monitor stamps every edge of `relay_on` with the clock count. Each check compares those stamps with the stimulus time plus the delay computed from the requirement. Sweeps cover pause counts 1 to 8 and interval request lengths from one clock up to the switch-on delay plus the pulse length.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ONDLY = 3'd1,
        ST_PULSE = 3'd2,
        ST_PARKW = 3'd3,
        ST_PAUSE = 3'd4,
        ST_WASH  = 3'd5,
        ST_DRY   = 3'd6
    } wstate_e;

endpackage

// File: rtl/wiper_debounce.sv
module wiper_debounce #(
    parameter int unsigned SET_TICKS = 8,
    parameter int unsigned CLR_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o
);

    localparam int unsigned MAXT = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
    localparam int unsigned CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t          q, d;
    logic [CW-1:0] lim_m1;

    always_comb begin
        d      = q;
        lim_m1 = q.level ? CW'(CLR_TICKS - 1) : CW'(SET_TICKS - 1);
        if (tick_i) begin
            if (raw_i == q.level) begin
                d.cnt = '0;
            end else if (q.cnt >= lim_m1) begin
                d.level = raw_i;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign level_o = q.level;

    // R11: the filtered level may only move after a tick
    p_level_needs_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.level) |-> $past(tick_i));

    // R5: the filtered level only ever moves toward the raw input
    p_level_follows_raw_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.level) |-> (q.level == $past(raw_i)));

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int unsigned ON_DLY_TICKS = 8,
    parameter int unsigned RELAY_TICKS  = 160,
    parameter int unsigned DRY_TICKS    = 896,
    parameter int unsigned DRY_CYCLES   = 3,
    parameter int unsigned PAUSE_W      = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               int_lvl_i,
    input  logic               wash_lvl_i,
    input  logic               park_lvl_i,
    input  logic               park_fb_i,
    input  logic [PAUSE_W-1:0] pause_ticks_i,
    output logic               relay_o
);

    localparam int unsigned W_REL = $clog2(RELAY_TICKS + 1);
    localparam int unsigned W_DRY = $clog2(DRY_TICKS + 1);
    localparam int unsigned W_DLY = $clog2(ON_DLY_TICKS + 1);
    localparam int unsigned W_A   = (W_REL > W_DRY) ? W_REL : W_DRY;
    localparam int unsigned W_B   = (W_A > W_DLY) ? W_A : W_DLY;
    localparam int unsigned CW    = (W_B > PAUSE_W) ? W_B : PAUSE_W;
    localparam int unsigned LW    = $clog2(DRY_CYCLES + 1);

    typedef struct packed {
        wstate_e       state;
        logic [CW-1:0] cnt;
        logic [LW-1:0] laps;
        logic          park_prev;
        logic          relay;
    } ctrl_t;

    ctrl_t         q, d;
    logic [CW-1:0] pause_m1;
    logic          park_rise;

    always_comb begin
        d           = q;
        pause_m1    = (pause_ticks_i == '0) ? '0 : (CW'(pause_ticks_i) - CW'(1));
        park_rise   = park_lvl_i && !q.park_prev;
        d.park_prev = park_lvl_i;

        case (q.state)
            ST_IDLE: begin
                if (int_lvl_i) begin
                    d.state = ST_ONDLY;
                    d.cnt   = '0;
                end
            end
            ST_ONDLY: begin
                if (tick_i) begin
                    if (q.cnt == CW'(ON_DLY_TICKS - 1)) begin
                        d.state = ST_PULSE;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (tick_i) begin
                    if (q.cnt == CW'(RELAY_TICKS - 1)) begin
                        d.cnt = '0;
                        if (!int_lvl_i)                    d.state = ST_IDLE;
                        else if (park_fb_i && !park_lvl_i) d.state = ST_PARKW;
                        else                               d.state = ST_PAUSE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PARKW: begin
                if (!int_lvl_i) begin
                    d.state = ST_IDLE;
                end else if (park_lvl_i) begin
                    d.state = ST_PAUSE;
                    d.cnt   = '0;
                end
            end
            ST_PAUSE: begin
                if (!int_lvl_i) begin
                    d.state = ST_IDLE;
                    d.cnt   = '0;
                end else if (tick_i) begin
                    if (q.cnt >= pause_m1) begin
                        d.state = ST_PULSE;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_WASH: begin
                if (!wash_lvl_i) begin
                    d.state = ST_DRY;
                    d.cnt   = '0;
                    d.laps  = '0;
                end
            end
            ST_DRY: begin
                if (park_fb_i) begin
                    if (park_rise) begin
                        if (q.laps == LW'(DRY_CYCLES - 1)) begin
                            d.state = ST_IDLE;
                            d.laps  = '0;
                        end else begin
                            d.laps = q.laps + 1'b1;
                        end
                    end
                end else if (tick_i) begin
                    if (q.cnt == CW'(DRY_TICKS - 1)) begin
                        d.state = ST_IDLE;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.cnt   = '0;
            end
        endcase

        // wash pre-empts every interval state
        if (wash_lvl_i) begin
            d.state = ST_WASH;
            d.cnt   = '0;
            d.laps  = '0;
        end

        d.relay = (d.state == ST_PULSE) || (d.state == ST_WASH) || (d.state == ST_DRY);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign relay_o = q.relay;

    // R8: a filtered wash level forces the relay on at the next clock
    p_wash_forces_relay_r8: assert property (@(posedge clk) disable iff (rst)
        wash_lvl_i |=> relay_o);

    // R2: the relay only switches on out of the delay, the pause, or a wash
    p_relay_rise_source_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(q.relay) |-> ($past(q.state) == ST_ONDLY || $past(q.state) == ST_PAUSE
                            || $past(wash_lvl_i)));

    // R3: the pulse counter never passes the pulse length
    p_pulse_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_PULSE) |-> (q.cnt < CW'(RELAY_TICKS)));

    // R12: a released request during the pause drops to idle
    p_pause_release_r12: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_PAUSE && !int_lvl_i && !wash_lvl_i) |=> (q.state == ST_IDLE));

    // R10: the lap counter stays below the lap count
    p_lap_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_DRY) |-> (q.laps < LW'(DRY_CYCLES)));

endmodule

// File: rtl/wiper_seq.sv
module wiper_seq #(
    parameter int unsigned INT_DEB_TICKS  = 32,
    parameter int unsigned ON_DLY_TICKS   = 8,
    parameter int unsigned RELAY_TICKS    = 160,
    parameter int unsigned WASH_ON_TICKS  = 128,
    parameter int unsigned WASH_OFF_TICKS = 32,
    parameter int unsigned PARK_DEB_TICKS = 8,
    parameter int unsigned DRY_TICKS      = 896,
    parameter int unsigned DRY_CYCLES     = 3,
    parameter int unsigned PAUSE_W        = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               int_req,
    input  logic               wash_req,
    input  logic               park_in,
    input  logic               park_fb_en,
    input  logic [PAUSE_W-1:0] pause_ticks,
    output logic               relay_on
);

    logic int_lvl, wash_lvl, park_lvl;

    wiper_debounce #(.SET_TICKS(INT_DEB_TICKS), .CLR_TICKS(INT_DEB_TICKS)) u_int_deb (
        .clk(clk), .rst(rst), .tick_i(tick), .raw_i(int_req), .level_o(int_lvl));

    wiper_debounce #(.SET_TICKS(WASH_ON_TICKS), .CLR_TICKS(WASH_OFF_TICKS)) u_wash_deb (
        .clk(clk), .rst(rst), .tick_i(tick), .raw_i(wash_req), .level_o(wash_lvl));

    wiper_debounce #(.SET_TICKS(PARK_DEB_TICKS), .CLR_TICKS(PARK_DEB_TICKS)) u_park_deb (
        .clk(clk), .rst(rst), .tick_i(tick), .raw_i(park_in), .level_o(park_lvl));

    wiper_ctrl #(
        .ON_DLY_TICKS(ON_DLY_TICKS),
        .RELAY_TICKS (RELAY_TICKS),
        .DRY_TICKS   (DRY_TICKS),
        .DRY_CYCLES  (DRY_CYCLES),
        .PAUSE_W     (PAUSE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .int_lvl_i    (int_lvl),
        .wash_lvl_i   (wash_lvl),
        .park_lvl_i   (park_lvl),
        .park_fb_i    (park_fb_en),
        .pause_ticks_i(pause_ticks),
        .relay_o      (relay_on)
    );

endmodule

// File: tb/tb_wiper_seq.sv
module tb_wiper_seq;

    localparam int N   = 4;
    localparam int D   = 3;
    localparam int R   = 10;
    localparam int WON = 12;
    localparam int WOF = 5;
    localparam int PD  = 3;
    localparam int DT  = 20;
    localparam int DC  = 3;
    localparam int PW  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b1;
    logic          int_req = 1'b0;
    logic          wash_req = 1'b0;
    logic          park_in = 1'b0;
    logic          park_fb_en = 1'b0;
    logic [PW-1:0] pause_ticks = 6'd5;
    logic          relay_on;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nr = 0;
    int nf = 0;
    int rise_t[16];
    int fall_t[16];
    logic prev_relay = 1'b0;
    int c0;

    wiper_seq #(
        .INT_DEB_TICKS(N), .ON_DLY_TICKS(D), .RELAY_TICKS(R),
        .WASH_ON_TICKS(WON), .WASH_OFF_TICKS(WOF), .PARK_DEB_TICKS(PD),
        .DRY_TICKS(DT), .DRY_CYCLES(DC), .PAUSE_W(PW)
    ) dut (
        .clk(clk), .rst(rst), .tick(tick), .int_req(int_req), .wash_req(wash_req),
        .park_in(park_in), .park_fb_en(park_fb_en), .pause_ticks(pause_ticks),
        .relay_on(relay_on)
    );

    always #4 clk = ~clk;

    // edge monitor, sampled 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        cyc = cyc + 1;
        if (relay_on && !prev_relay && nr < 16) begin
            rise_t[nr] = cyc;
            nr = nr + 1;
        end
        if (!relay_on && prev_relay && nf < 16) begin
            fall_t[nf] = cyc;
            nf = nf + 1;
        end
        prev_relay = relay_on;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic i, input logic w, input logic pk,
                         input logic fb, input int p);
        @(negedge clk);
        rst = 1'b1;
        tick = 1'b1;
        int_req = i;
        wash_req = w;
        park_in = pk;
        park_fb_en = fb;
        pause_ticks = PW'(p);
        wait_cyc(3);
        nr = 0;
        nf = 0;
        rst = 1'b0;
        c0 = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        chk("R1 relay low in reset", int'(relay_on), 0);

        // R2 R3 R6: pause sweep without park feedback
        for (int p = 1; p <= 8; p++) begin
            start(1'b1, 1'b0, 1'b0, 1'b0, p);
            wait_cyc(N + D + 3 * (R + p) + 10);
            chk("R2 first rise delay", rise_t[0] - c0, N + D + 1);
            chk("R3 pulse width", fall_t[0] - rise_t[0], R);
            chk("R6 pause period", rise_t[1] - rise_t[0], R + p);
            chk("R6 pause period 2", rise_t[2] - rise_t[1], R + p);
        end

        // R6: pause count 0 acts as 1
        start(1'b1, 1'b0, 1'b0, 1'b0, 0);
        wait_cyc(N + D + 2 * R + 10);
        chk("R6 zero pause", rise_t[1] - rise_t[0], R + 1);

        // R4 R5: short request sweep
        for (int len = 1; len <= D + R; len++) begin
            start(1'b0, 1'b0, 1'b0, 1'b0, 20);
            int_req = 1'b1;
            wait_cyc(len);
            int_req = 1'b0;
            wait_cyc(N + D + R + 40);
            if (len < N) begin
                chk("R5 short request no pulse", nr, 0);
            end else begin
                chk("R4 single pulse", nr, 1);
                chk("R4 single pulse width", fall_t[0] - rise_t[0], R);
            end
        end

        // R7: park feedback controls the pause start
        start(1'b1, 1'b0, 1'b1, 1'b1, 6);
        wait_cyc(N + D + 2);
        park_in = 1'b0;
        wait_cyc(R + 6 + 10);
        chk("R7 no pause while away from park", nr, 1);
        begin
            int cp;
            cp = cyc;
            park_in = 1'b1;
            wait_cyc(PD + 6 + 5);
            chk("R7 pause after park filter", rise_t[1] - cp, PD + 6 + 1);
        end

        // R12: release during pause
        start(1'b1, 1'b0, 1'b0, 1'b0, 40);
        wait_cyc(N + D + R + 3);
        int_req = 1'b0;
        wait_cyc(80);
        chk("R12 no pulse after release", nr, 1);
        chk("R12 relay low", int'(relay_on), 0);

        // R8 R9: wash without park feedback
        start(1'b0, 1'b1, 1'b0, 1'b0, 5);
        wait_cyc(WON + 30);
        chk("R8 wash rise delay", rise_t[0] - c0, WON + 1);
        chk("R8 relay held while washing", int'(relay_on), 1);
        begin
            int cr;
            cr = cyc;
            wash_req = 1'b0;
            wait_cyc(WOF + DT + 5);
            chk("R9 dry time", fall_t[0] - cr, WOF + DT + 1);
        end

        // R8: wash pre-empts the interval pause, interval resumes afterwards
        start(1'b1, 1'b0, 1'b0, 1'b0, 30);
        wait_cyc(N + D + R + 2);
        begin
            int cw;
            int cr;
            cw = cyc;
            wash_req = 1'b1;
            wait_cyc(WON + 40);
            chk("R8 wash during pause", rise_t[1] - cw, WON + 1);
            chk("R8 no interval drop while washing", nf, 1);
            cr = cyc;
            wash_req = 1'b0;
            wait_cyc(WOF + DT + D + 6);
            chk("R9 dry end after wash in interval", fall_t[1] - cr, WOF + DT + 1);
            chk("R8 interval resumes", rise_t[2] - fall_t[1], D + 1);
        end

        // R10: dry laps with park feedback
        start(1'b0, 1'b1, 1'b1, 1'b1, 5);
        wait_cyc(WON + 4);
        park_in = 1'b0;
        wait_cyc(10);
        wash_req = 1'b0;
        wait_cyc(WOF + 2);
        begin
            int cp;
            cp = 0;
            for (int k = 0; k < DC; k++) begin
                if (k == DC - 1) cp = cyc;
                park_in = 1'b1;
                wait_cyc(6);
                if (k < DC - 1) begin
                    chk("R10 relay on between laps", int'(relay_on), 1);
                    park_in = 1'b0;
                    wait_cyc(6);
                end
            end
            wait_cyc(4);
            chk("R10 dry ends on last lap", fall_t[0] - cp, PD + 1);
        end

        // R11: no progress without tick, stretched pulse
        start(1'b1, 1'b0, 1'b0, 1'b0, 8);
        tick = 1'b0;
        wait_cyc(50);
        chk("R11 frozen without tick", nr, 0);
        begin
            int c1;
            c1 = cyc;
            tick = 1'b1;
            wait_cyc(N + D + 3);
            chk("R11 rise after tick resumes", rise_t[0] - c1, N + D + 1);
            tick = 1'b0;
            wait_cyc(20);
            tick = 1'b1;
            wait_cyc(R + 2);
            chk("R11 pulse stretched by frozen ticks", fall_t[0] - rise_t[0], R + 20);
        end

        // R1: reset mid-pulse, held request restarts from scratch
        start(1'b1, 1'b0, 1'b0, 1'b0, 8);
        wait_cyc(N + D + 3);
        rst = 1'b1;
        wait_cyc(1);
        chk("R1 reset drops relay", int'(relay_on), 0);
        wait_cyc(2);
        nr = 0;
        nf = 0;
        begin
            int c3;
            c3 = cyc;
            rst = 1'b0;
            wait_cyc(N + D + 3);
            chk("R1 full delay after reset", rise_t[0] - c3, N + D + 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule